// File: doc/BRIEF.md
# Programmable eight-line interrupt controller

The block collects eight interrupt request lines, qualifies each one as level-sensed or edge-sensed, and offers the highest-priority eligible request to a processor. Line 0 has the highest priority and line 7 the lowest. Software drives the block through a byte-wide command port and a byte-wide data port. A command byte can restart initialization, end an interrupt, or set up readback and polling. After a restart, the next three data bytes program the vector base and two configuration words. Outside initialization, data writes load the mask register.

Edge-sensed lines are qualified by a per-line "seen low" flag rather than by an edge detector. A line that has been acknowledged cannot request again until it has gone low and then high. The processor takes a request either by pulsing `ack_i` or by reading the command port while poll is armed. It receives an 8-bit vector and a valid flag. The block serves the primary slot of a cascade by default; the `IS_PRIMARY` parameter selects the reset vector base.

Top module: `irq_ctrl8`

## Requirements
- R1: The effective request vector is `irq_i & (sense | seen_low)`. A sense bit of 1 selects level mode, in which a line requests whenever it is high and stays requesting after it is acknowledged.
- R2: After reset or a restart, every `seen_low` bit is 1. A line sampled low sets its bit, and acknowledging the line clears it. An edge-mode line that stays high after its acknowledge does not request again until it falls and rises.
- R3: A line is eligible when it is requested, unmasked, and has a lower index than the lowest set in-service bit. All lines are below that bit when the in-service register is empty. The lowest eligible index is served, and `pending_o` is 1 exactly when some line is eligible.
- R4: An acknowledge with an eligible line gives `vec_valid_o`=1 and `vec_o` = {base[7:3], line[2:0]}, and sets that line's in-service bit on the clock edge.
- R5: An acknowledge with no eligible line gives `vec_o` = base | 7 and `vec_valid_o`=0, and changes no state.
- R6: A command write with bit 4 set restarts initialization. It clears the mask, the in-service register and the control byte, reloads the reset base, and sets all seen-low bits. The sense register is kept. The block then expects the base word.
- R7: After a restart, data writes are taken in order as the base (bits [2:0] forced to 0), the cascade word and the mode word; the block is then initialized. Before any restart, and once initialized, data writes load the mask.
- R8: A command write with bits 4 and 3 clear and bits [7:5] = 011 clears the in-service bit selected by bits [2:0].
- R9: A command write with bits 4 and 3 clear and bits [7:5] = 001 clears the lowest set in-service bit. Every other combination of bits [7:5] changes nothing.
- R10: A command write with bit 3 set and bit 4 clear loads the control byte. In it, bit 1 enables readback, bit 0 selects in-service (1) or request (0) readback, and bit 2 arms poll. With poll clear, a command read returns the selected register, or 0 when readback is disabled.
- R11: A command read with poll armed returns {valid, 4'b0, line[2:0]}, performs an acknowledge as R4/R5 describe, and clears the poll bit.
- R12: `mask_o` always shows the mask register. Reset gives mask 0, in-service 0, control 0, the stage before initialization, and a base of 0 (primary) or 8 (secondary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Request line levels, synchronous to clk_i |
| wdata_i | input | 8 | Write data shared by all write strobes |
| cmd_we_i | input | 1 | Command port write strobe |
| data_we_i | input | 1 | Data port write strobe |
| sense_we_i | input | 1 | Edge/level select register write strobe |
| cmd_re_i | input | 1 | Command port read strobe (poll side effect) |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_rdata_o | output | 8 | Command port read data |
| mask_o | output | 8 | Data port read data (mask register) |
| pending_o | output | 1 | Some line is eligible |
| vec_o | output | 8 | Vector for the current acknowledge |
| vec_valid_o | output | 1 | Vector refers to a real request |

## Verification
The assertions assume that `irq_i` is synchronous to the clock and that at most one of the three write strobes is high in any cycle. The acknowledge and poll-read strobes may coincide with a write. The stimulus changes every input only at the falling edge and picks a single write kind per cycle. It mixes random command bytes, including occasional restarts and every end-of-interrupt variant, with random line levels that often hold steady so that edge-mode lines are seen both staying high and toggling.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NLINES = 8;
  localparam int unsigned IDX_W  = $clog2(NLINES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_READY
  } init_st_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lines_i,
  input  logic [N-1:0] sense_i,
  input  logic         restart_i,
  input  logic [N-1:0] ack_oh_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] seen_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_low_q <= '1;
    else if (restart_i) seen_low_q <= '1;
    else                seen_low_q <= (seen_low_q & ~ack_oh_i) | ~lines_i;
  end

  assign irr_o = lines_i & (sense_i | seen_low_q);

  a_r2_low_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((seen_low_q & ~$past(lines_i)) == ~$past(lines_i)));
  a_r2_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_oh_i != '0 && !restart_i) |=> ((seen_low_q & $past(ack_oh_i)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  isr_i,
  output logic [N-1:0]  pick_oh_o,
  output logic [IW-1:0] pick_idx_o,
  output logic          any_o
);
  logic [N-1:0] lowest_isr, below_isr, elig;

  always_comb begin
    lowest_isr = isr_i & (~isr_i + 1'b1);
    below_isr  = lowest_isr - 1'b1;   // all ones when nothing in service
    elig       = irr_i & ~mask_i & below_isr;
    pick_oh_o  = elig & (~elig + 1'b1);
    any_o      = |elig;
    pick_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) pick_idx_o = i[IW-1:0];
    end
  end

  a_r3_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_oh_o));
  a_r3_above_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_o && isr_i != '0) |-> (pick_oh_o < (isr_i & (~isr_i + 1'b1))));
  a_r3_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((pick_oh_o & (mask_i | ~irr_i)) == '0));
endmodule

// File: rtl/irq_cmd_dec.sv
module irq_cmd_dec #(
  parameter int unsigned N = 8
) (
  input  logic         cmd_we_i,
  input  logic [7:0]   wdata_i,
  input  logic [N-1:0] isr_i,
  output logic         restart_o,
  output logic         ctrl_we_o,
  output logic [N-1:0] eoi_clr_o
);
  logic ocw, eoi_cmd;

  always_comb begin
    restart_o = cmd_we_i & wdata_i[4];
    ocw       = cmd_we_i & ~wdata_i[4];
    ctrl_we_o = ocw & wdata_i[3];
    // only EOI=1, R=0 acts; SL picks specific vs lowest
    eoi_cmd   = ocw & ~wdata_i[3] & wdata_i[5] & ~wdata_i[7];
    eoi_clr_o = '0;
    if (eoi_cmd) begin
      if (wdata_i[6]) eoi_clr_o[wdata_i[2:0]] = 1'b1;
      else            eoi_clr_o = isr_i & (~isr_i + 1'b1);
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irq_ctrl_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] irq_i,
  input  logic [7:0] wdata_i,
  input  logic       cmd_we_i,
  input  logic       data_we_i,
  input  logic       sense_we_i,
  input  logic       cmd_re_i,
  input  logic       ack_i,
  output logic [7:0] cmd_rdata_o,
  output logic [7:0] mask_o,
  output logic       pending_o,
  output logic [7:0] vec_o,
  output logic       vec_valid_o
);
  localparam logic [7:0] BASE_RST = IS_PRIMARY ? 8'h00 : 8'h08;

  logic [NLINES-1:0] isr_q, mask_q, sense_q, irr, pick_oh, ack_oh, eoi_clr;
  logic [7:0]        base_q, ctrl_q;
  logic [IDX_W-1:0]  pick_idx;
  logic              any, restart, ctrl_we, do_ack, poll_rd;
  init_st_e          st_q;

  irq_cmd_dec #(.N(NLINES)) u_dec (
    .cmd_we_i (cmd_we_i),
    .wdata_i  (wdata_i),
    .isr_i    (isr_q),
    .restart_o(restart),
    .ctrl_we_o(ctrl_we),
    .eoi_clr_o(eoi_clr)
  );

  irq_req_latch #(.N(NLINES)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (irq_i),
    .sense_i  (sense_q),
    .restart_i(restart),
    .ack_oh_i (ack_oh),
    .irr_o    (irr)
  );

  irq_prio_pick #(.N(NLINES)) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irr_i     (irr),
    .mask_i    (mask_q),
    .isr_i     (isr_q),
    .pick_oh_o (pick_oh),
    .pick_idx_o(pick_idx),
    .any_o     (any)
  );

  assign poll_rd     = cmd_re_i & ctrl_q[2];
  assign do_ack      = ack_i | poll_rd;
  assign ack_oh      = do_ack ? pick_oh : '0;
  assign pending_o   = any;
  assign vec_valid_o = any;
  assign vec_o       = any ? {base_q[7:3], pick_idx} : (base_q | 8'h07);
  assign mask_o      = mask_q;

  always_comb begin
    if (ctrl_q[2])      cmd_rdata_o = {any, 4'b0, pick_idx};
    else if (ctrl_q[1]) cmd_rdata_o = ctrl_q[0] ? isr_q : irr;
    else                cmd_rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      base_q <= BASE_RST;
      st_q   <= ST_IDLE;
    end else if (restart) begin
      isr_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      base_q <= BASE_RST;
      st_q   <= ST_BASE;
    end else begin
      isr_q <= (isr_q | ack_oh) & ~eoi_clr;
      if (ctrl_we)      ctrl_q    <= wdata_i;
      else if (poll_rd) ctrl_q[2] <= 1'b0;
      if (data_we_i) begin
        unique case (st_q)
          ST_BASE: begin
            base_q <= {wdata_i[7:3], 3'b000};
            st_q   <= ST_CASC;
          end
          ST_CASC: st_q <= ST_MODE;
          ST_MODE: st_q <= ST_READY;
          default: mask_q <= wdata_i;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sense_q <= '0;
    else if (sense_we_i) sense_q <= wdata_i;
  end

  a_r4_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_ack && any && !cmd_we_i) |=> ((isr_q & $past(pick_oh)) != '0));
  a_r5_idle_ack_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_ack && !any && !cmd_we_i && !data_we_i) |=> $stable(isr_q) && $stable(mask_q));
  a_r6_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i[4]) |=> (isr_q == '0 && mask_q == '0 && ctrl_q == '0 && base_q == BASE_RST));
  a_r8_specific_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i[7:3] == 5'b01100) |=> !isr_q[$past(wdata_i[2:0])]);
  a_r11_poll_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && !cmd_we_i) |=> !ctrl_q[2]);
  a_r7_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && st_q == ST_BASE && !cmd_we_i) |=> (vec_o[7:3] == $past(wdata_i[7:3])));
endmodule

// File: tb/tb_irq_ctrl8.sv
module tb_irq_ctrl8;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [7:0] irq, wdata, cmd_rdata, mask, vec;
  logic       cmd_we, data_we, sense_we, cmd_re, ack, pending, vec_valid;

  irq_ctrl8 dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wdata_i(wdata),
    .cmd_we_i(cmd_we), .data_we_i(data_we), .sense_we_i(sense_we),
    .cmd_re_i(cmd_re), .ack_i(ack), .cmd_rdata_o(cmd_rdata),
    .mask_o(mask), .pending_o(pending), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state, written from the requirements
  logic [7:0] m_isr = 8'h00, m_mask = 8'h00, m_base = 8'h00, m_sense = 8'h00;
  logic [7:0] m_low = 8'hFF, m_ctrl = 8'h00;
  int         m_st = 0;  // 0 idle, 1 base, 2 cascade, 3 mode, 4 ready

  function automatic logic [7:0] f_irr(input logic [7:0] ln);
    return ln & (m_sense | m_low);
  endfunction

  function automatic logic [7:0] f_elig(input logic [7:0] ln);
    logic [7:0] low_isr;
    low_isr = m_isr & (~m_isr + 8'd1);
    return f_irr(ln) & ~m_mask & (low_isr - 8'd1);
  endfunction

  function automatic logic [3:0] f_idx(input logic [7:0] e);
    for (int i = 0; i < 8; i++) if (e[i]) return i[3:0];
    return 4'd8;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] ln, input logic wc, input logic wd, input logic sw,
                      input logic ak, input logic rc, input logic [7:0] d, input string tag);
    logic [7:0] e, clr, ackoh;
    logic [3:0] idx;
    logic       any, doack;
    @(negedge clk);
    irq = ln; cmd_we = wc; data_we = wd; sense_we = sw; ack = ak; cmd_re = rc; wdata = d;
    #1;
    e = f_elig(ln); idx = f_idx(e); any = (e != 8'h00);
    chk({tag, " pending R3"}, {7'b0, pending}, {7'b0, any});
    chk({tag, " mask R12"}, mask, m_mask);
    doack = ak | (rc & m_ctrl[2]);
    if (doack) begin
      chk({tag, " vector R4/R5"}, vec, any ? {m_base[7:3], idx[2:0]} : (m_base | 8'h07));
      chk({tag, " valid R4"}, {7'b0, vec_valid}, {7'b0, any});
    end
    if (rc) begin
      if (m_ctrl[2])      chk({tag, " poll R11"}, cmd_rdata, {any, 4'b0, idx[2:0]});
      else if (m_ctrl[1]) chk({tag, " readback R10"}, cmd_rdata, m_ctrl[0] ? m_isr : f_irr(ln));
      else                chk({tag, " readback off R10"}, cmd_rdata, 8'h00);
    end
    @(posedge clk);
    ackoh = (doack && any) ? (8'd1 << idx[2:0]) : 8'h00;
    if (wc && d[4]) begin
      m_isr = 0; m_mask = 0; m_ctrl = 0; m_base = 8'h00; m_low = 8'hFF; m_st = 1;
    end else begin
      clr = 8'h00;
      if (wc && !d[3] && d[5] && !d[7]) clr = d[6] ? (8'd1 << d[2:0]) : (m_isr & (~m_isr + 8'd1));
      m_low = (m_low & ~ackoh) | ~ln;
      m_isr = (m_isr | ackoh) & ~clr;
      if (wc && d[3])               m_ctrl = d;
      else if (rc && m_ctrl[2])     m_ctrl[2] = 1'b0;
      if (wd) begin
        case (m_st)
          1: begin m_base = {d[7:3], 3'b000}; m_st = 2; end
          2: m_st = 3;
          3: m_st = 4;
          default: m_mask = d;
        endcase
      end
    end
    if (sw) m_sense = d;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ln, d;
    int op;
    void'($urandom(32'd20240611));
    rst_n = 0; irq = 0; wdata = 0; cmd_we = 0; data_we = 0; sense_we = 0; cmd_re = 0; ack = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R12 reset state, R5 empty acknowledge, R7 mask load before init
    step(8'h00, 0, 0, 0, 1, 0, 8'h00, "R12 reset");
    step(8'h00, 0, 1, 0, 0, 0, 8'h5A, "R7 mask pre-init");
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, "R12 mask read");
    // R6 restart then R7 init words, base low bits dropped
    step(8'h00, 1, 0, 0, 0, 0, 8'h11, "R6 restart");
    step(8'h00, 0, 1, 0, 0, 0, 8'h35, "R7 base");
    step(8'h00, 0, 1, 0, 0, 0, 8'h04, "R7 cascade");
    step(8'h00, 0, 1, 0, 0, 0, 8'h01, "R7 mode");
    step(8'h00, 0, 1, 0, 0, 0, 8'hF0, "R7 mask after init");
    // R1/R2 edge line: request, acknowledge, held high stays quiet
    step(8'h0A, 0, 0, 0, 0, 0, 8'h00, "R1 edge request");
    step(8'h0A, 0, 0, 0, 1, 0, 8'h00, "R4 ack line1");
    step(8'h0A, 1, 0, 0, 0, 0, 8'h20, "R9 nonspecific eoi");
    step(8'h0A, 0, 0, 0, 1, 0, 8'h00, "R3 line3 next");
    step(8'h0A, 1, 0, 0, 0, 0, 8'h20, "R9 eoi");
    step(8'h0A, 0, 0, 0, 1, 0, 8'h00, "R2 held high no request");
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, "R2 fall");
    step(8'h02, 0, 0, 0, 0, 0, 8'h00, "R2 rise requests");
    // R1 level line persists after ack and specific eoi
    step(8'h02, 0, 0, 1, 0, 0, 8'h01, "R1 sense write");
    step(8'h01, 0, 0, 0, 1, 0, 8'h00, "R1 level ack");
    step(8'h01, 1, 0, 0, 0, 0, 8'h60, "R8 specific eoi");
    step(8'h01, 0, 0, 0, 0, 0, 8'h00, "R1 level still pending");
    step(8'h01, 1, 0, 0, 0, 0, 8'h0A, "R10 irr readback");
    step(8'h01, 0, 0, 0, 0, 1, 8'h00, "R10 read irr");
    step(8'h03, 0, 0, 0, 1, 0, 8'h00, "R4 ack level");
    step(8'h03, 1, 0, 0, 0, 0, 8'hA0, "R9 rotate ignored");
    step(8'h03, 1, 0, 0, 0, 0, 8'h0B, "R10 isr readback");
    step(8'h03, 0, 0, 0, 0, 1, 8'h00, "R10 read isr");
    step(8'h03, 1, 0, 0, 0, 0, 8'h60, "R8 eoi line0");
    step(8'h03, 1, 0, 0, 0, 0, 8'h0C, "R11 arm poll");
    step(8'h03, 0, 0, 0, 0, 1, 8'h00, "R11 poll read");
    step(8'h03, 0, 0, 0, 0, 1, 8'h00, "R11 poll cleared");
    step(8'h03, 0, 0, 0, 0, 0, 8'h00, "R11 after");
    step(8'h03, 1, 0, 0, 0, 0, 8'h11, "R6 restart keeps sense");
    step(8'h03, 0, 0, 0, 1, 0, 8'h00, "R6 ack after restart");
    // random mix
    ln = 8'h00;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 4 == 0) ln = ln ^ (8'd1 << ($urandom % 8));
      d = 8'($urandom);
      op = $urandom % 10;
      if (op == 0 && d[4] && ($urandom % 6 != 0)) d[4] = 1'b0;
      step(ln, op < 3, op == 3 || op == 4, op == 5, ($urandom % 4) == 0,
           ($urandom % 5) == 0, d, "random");
    end
    step(ln, 0, 0, 0, 0, 0, 8'h00, "final");
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule